// File: doc/BRIEF.md
# Parallel LFSR Transmit Scrambler

This block whitens a parallel transmit word in one clock cycle, ahead of a serializer that shifts out bit 0 of every word first. A 15-bit linear feedback shift register with feedback polynomial x^15 + x + 1 supplies one keystream bit for each serial bit time. Each clock the register is advanced by DWIDTH serial steps at once, and every data lane is XORed with its own keystream bit.

The register is kept in reversed order so that register bit k lines up with data bit k. One serial step moves every bit one place toward bit 0. The new bit 14 is the XOR of the old bits 1 and 0. Lane 0 uses bit 0 of the current state. Lane j uses bit 0 of the state reached after j steps. The state reached after DWIDTH steps becomes the state for the next word.

A 15-bit seed is loaded while the synchronous active-low reset is held. A seed of zero is replaced by all ones, because a zero state would never leave zero. DWIDTH defaults to 16, and a width below 15 stops elaboration with an error.

Top module: `par_scrambler`

## Requirements
- R1: At every rising clock edge where rst_n is low, dout is cleared to zero.
- R2: For the first word accepted after reset, bit j of dout equals din[j] XOR bit 0 of the seed after j serial steps. One step maps state s to {s[1]^s[0], s[14:1]}, and step 0 is the seed itself.
- R3: A seed of 15'h0000 is loaded as 15'h7FFF, so the first 15 keystream bits after such a reset are all ones.
- R4: Successive words continue one unbroken serial keystream: each word starts from the state reached after DWIDTH steps of the word before it.
- R5: dout shows the scrambled value of the din word sampled at the previous rising edge, a latency of exactly one clock.
- R6: An all-zero input stream produces the raw keystream. That keystream has period 32767, and all 32767 of its 15-bit windows are distinct and nonzero.
- R7: Across more than 1000 random words, dout matches a bit-serial model that advances one step per bit, LSB first, for both DWIDTH=16 and DWIDTH=15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the seed is loaded while it is low |
| seed_in | input | 15 | Seed for the register, with bit k lined up with lane k |
| din | input | DWIDTH | Parallel word to scramble; bit 0 is sent first |
| dout | output | DWIDTH | Registered scrambled word |

## Verification
The bench builds two copies of the block side by side: the default DWIDTH=16, and the minimum DWIDTH=15. Both are fed the same stimulus. At width 15 every bit of the next state comes from a keystream lane of the current word, so the word-to-word handoff has no spare margin. At width 16 the word boundary does not fall on a multiple of the register length, which exposes any off-by-one in the unroll. Running the wider copy on zeros for more than two full periods makes the period and distinct-window property observable at the ports.

// File: rtl/scr_pkg.sv
package scr_pkg;
    localparam int LFSR_W = 15;
    localparam logic [LFSR_W-1:0] SEED_ALLONES = {LFSR_W{1'b1}};

    // one serial bit time: shift toward bit 0, feedback enters at the top
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[1] ^ s[0], s[LFSR_W-1:1]};
    endfunction
endpackage

// File: rtl/scr_seed_guard.sv
module scr_seed_guard
    import scr_pkg::*;
(
    input  logic [LFSR_W-1:0] seed_i,
    output logic [LFSR_W-1:0] seed_o
);
    // a zero state is a fixed point of the register, so swap it out
    assign seed_o = (seed_i == '0) ? SEED_ALLONES : seed_i;
endmodule

// File: rtl/scr_keystream.sv
module scr_keystream
    import scr_pkg::*;
#(
    parameter int DWIDTH = 16
) (
    input  logic [LFSR_W-1:0] state_i,
    output logic [DWIDTH-1:0] key_o,
    output logic [LFSR_W-1:0] next_o
);
    // walk[j] is the register after j serial bit times
    logic [DWIDTH:0][LFSR_W-1:0] walk;

    assign walk[0] = state_i;

    for (genvar g = 0; g < DWIDTH; g++) begin : g_lane
        assign key_o[g]    = walk[g][0];
        assign walk[g + 1] = lfsr_step(walk[g]);
    end

    assign next_o = walk[DWIDTH];
endmodule

// File: rtl/par_scrambler.sv
module par_scrambler
    import scr_pkg::*;
#(
    parameter int DWIDTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [scr_pkg::LFSR_W-1:0] seed_in,
    input  logic [DWIDTH-1:0]        din,
    output logic [DWIDTH-1:0]        dout
);
    if (DWIDTH < LFSR_W) begin : g_width_guard
        $error("par_scrambler: DWIDTH must be at least 15");
    end

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic [DWIDTH-1:0] word;
    } scr_state_t;

    scr_state_t        state_d, state_q;
    logic [LFSR_W-1:0] seed_safe;
    logic [DWIDTH-1:0] key;
    logic [LFSR_W-1:0] lfsr_adv;
    logic              rst_low_q;

    scr_seed_guard i_seed (
        .seed_i (seed_in),
        .seed_o (seed_safe)
    );

    scr_keystream #(.DWIDTH(DWIDTH)) i_key (
        .state_i (state_q.lfsr),
        .key_o   (key),
        .next_o  (lfsr_adv)
    );

    always_comb begin
        state_d = state_q;
        if (!rst_n) begin
            state_d.lfsr = seed_safe;
            state_d.word = '0;
        end else begin
            state_d.lfsr = lfsr_adv;
            state_d.word = din ^ key;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign dout = state_q.word;

    // R1: an edge that saw reset low leaves the output cleared
    always_ff @(posedge clk) begin
        rst_low_q <= !rst_n;
        if (rst_low_q) begin
            a_r1_zero_in_reset: assert (state_q.word == '0)
                else $error("R1: output not cleared by reset");
        end
    end

    // R2: the first 15 lanes read the stored register bits one for one
    a_r2_lanes_match_state: assert property (@(posedge clk) disable iff (!rst_n)
        key[LFSR_W-1:0] == state_q.lfsr);

    // R3: the register never holds the all-zero lock-up state
    a_r3_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.lfsr != '0);

    // R4: lane 0 of a word obeys the recurrence over the previous word's lanes
    a_r4_word_continuity: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> key[0] == $past(key[DWIDTH-15] ^ key[DWIDTH-14]));
endmodule

// File: tb/test_par_scrambler.sv
`timescale 1ns/1ps
module test_par_scrambler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] seed = 15'h1ACE;
    logic [15:0] din16 = '0;
    logic [14:0] din15 = '0;
    logic [15:0] dout16;
    logic [14:0] dout15;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [14:0] s16, s15;
    logic [63:0] e16, e15;
    bit have_exp = 1'b0;
    bit collect = 1'b0;
    bit ks [0:69999];
    int nbits = 0;
    bit seen [0:32767];

    always #10 clk = ~clk;

    par_scrambler #(.DWIDTH(16)) i_par_scrambler (
        .clk(clk), .rst_n(rst_n), .seed_in(seed), .din(din16), .dout(dout16));
    par_scrambler #(.DWIDTH(15)) i_par_scrambler_w15 (
        .clk(clk), .rst_n(rst_n), .seed_in(seed), .din(din15), .dout(dout15));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // serial reference: one bit time per loop pass, bit 0 leaves first
    task automatic model_word(inout logic [14:0] s, input logic [63:0] d,
                              input int w, output logic [63:0] o);
        o = '0;
        for (int b = 0; b < w; b++) begin
            o[b] = d[b] ^ s[0];
            s = {s[1] ^ s[0], s[14:1]};
        end
    endtask

    task automatic cycle(input string tag, input logic [63:0] d);
        @(negedge clk);
        if (have_exp) begin
            chk({tag, " w16"}, {48'h0, dout16}, {48'h0, e16[15:0]});
            chk({tag, " w15"}, {49'h0, dout15}, {49'h0, e15[14:0]});
            if (collect) begin
                for (int b = 0; b < 16; b++) begin
                    if (nbits < 70000) begin
                        ks[nbits] = dout16[b];
                        nbits++;
                    end
                end
            end
        end
        din16 = d[15:0];
        din15 = d[14:0];
        model_word(s16, d, 16, e16);
        model_word(s15, d, 15, e15);
        have_exp = 1'b1;
    endtask

    task automatic do_reset(input logic [14:0] sd, input int n, input logic [63:0] first);
        @(negedge clk);
        rst_n = 1'b0;
        seed = sd;
        have_exp = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk("R1 reset clears w16", {48'h0, dout16}, 64'h0);
            chk("R1 reset clears w15", {49'h0, dout15}, 64'h0);
        end
        s16 = (sd == 15'h0) ? 15'h7FFF : sd;
        s15 = s16;
        rst_n = 1'b1;
        din16 = first[15:0];
        din15 = first[14:0];
        model_word(s16, first, 16, e16);
        model_word(s15, first, 15, e15);
        have_exp = 1'b1;
    endtask

    initial begin
        int bad;
        logic [14:0] win;
        // R1, R2, R5: seeded reset, then the first word arrives one clock later
        do_reset(15'h1ACE, 3, 64'h0000_0000_0000_A5C3);
        cycle("R2 R5 first word after reset", 64'h0000_0000_0000_3C5A);
        // R4, R7: long random stream against the serial model
        for (int k = 0; k < 1200; k++) begin
            cycle("R4 R7 random word", {$urandom, $urandom});
        end
        cycle("R7 all ones word", 64'h0000_0000_0000_FFFF);
        // R1: reset in the middle of traffic, new seed takes over
        do_reset(15'h4001, 2, 64'h0000_0000_0000_0F0F);
        for (int k = 0; k < 50; k++) begin
            cycle("R2 R4 after mid-stream reset", {$urandom, $urandom});
        end
        // R3, R6: zero seed, zero data exposes the raw keystream
        do_reset(15'h0000, 2, 64'h0);
        collect = 1'b1;
        for (int k = 0; k < 4200; k++) begin
            cycle("R6 zero input", 64'h0);
        end
        collect = 1'b0;
        bad = 0;
        for (int b = 0; b < 15; b++) begin
            if (ks[b] != 1'b1) bad++;
        end
        chk("R3 zero seed gives all-ones start", bad, 0);
        chk("R6 enough keystream bits", (nbits >= 65549), 1);
        bad = 0;
        for (int i = 0; i < 32767; i++) begin
            for (int b = 0; b < 15; b++) win[b] = ks[i + b];
            if (win == 15'h0 || seen[win]) bad++;
            seen[win] = 1'b1;
            if (ks[i] != ks[i + 32767]) bad++;
        end
        chk("R6 period 32767 with distinct windows", bad, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule